// File: doc/BRIEF.md
# Deferred-Byte USB Data CRC16 Checker

This block verifies the 16-bit CRC that closes a USB data packet. A receiver hands it payload bytes, including the two transmitted CRC bytes, on a valid/data strobe, framed by a one-cycle start pulse and a one-cycle end pulse. The register update is the reflected, LSB-first form of the CRC16 generator. Each step uses a lookup entry that is computed combinationally from the generator polynomial, so no stored table is needed.

The fold is deferred by one byte. When a byte arrives, the pending lookup for the previous byte runs and the new byte is XORed into the low register byte. The lookup for that new byte waits for the next byte. To make this pipeline start from the logical value 0xFFFF, a start pulse preloads the register with 0xFE54. That value is exactly the one that becomes 0xFFFF after a virtual zero byte is folded in. At the end pulse a closing lookup flushes the last byte. The result is then compared with the fixed USB residue 0xB001. A mismatch produces a done pulse with a low ok flag and nothing else, so the packet is dropped silently and the host retries.

Top module: `usb_crc16_checker`

## Requirements
- R1: While reset is high, and in the first cycle after it, crc_reg_o reads 0xFE54 and done_o and crc_ok_o are 0.
- R2: After an accepted end pulse, crc_reg_o holds the reflected CRC16 over every byte accepted in the packet, in arrival order. That CRC uses polynomial 0xA001, starts from 0xFFFF, processes each byte bit 0 first, and applies no final inversion. Idle cycles between bytes have no effect on it.
- R3: In the done cycle, crc_ok_o is 1 exactly when crc_reg_o equals 0xB001. A packet whose last two bytes are the one's complement of the payload CRC, low byte first, therefore yields crc_ok_o = 1. Any single flipped bit yields 0.
- R4: done_o is high for exactly one cycle, namely the cycle after the clock edge that accepted the end pulse. It is low in every other cycle.
- R5: crc_ok_o is never high while done_o is low.
- R6: A start pulse without a byte leaves crc_reg_o at 0xFE54 in the next cycle. This holds even if a packet was still open.
- R7: A byte presented in the same cycle as the start pulse is taken as the first byte of the new packet.
- R8: A byte presented in the same cycle as the end pulse is taken as the last byte of the packet, ahead of the closing step.
- R9: While no packet is open, valid bytes are ignored and crc_reg_o keeps its value.
- R10: An end pulse with no packet open, or in the same cycle as a start pulse, is ignored: it produces no done_o. In the second case the new packet stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that opens a packet and preloads the register |
| byte_valid_i | input | 1 | Qualifies byte_i |
| byte_i | input | 8 | Received packet byte |
| end_i | input | 1 | One-cycle pulse that closes the open packet |
| crc_ok_o | output | 1 | Residue matched; valid only with done_o |
| done_o | output | 1 | One-cycle strobe after an accepted end pulse |
| crc_reg_o | output | 16 | Raw CRC register, high byte in bits 15:8 |

## Verification
A byte can arrive in the same cycle as the start pulse, and a byte can arrive in the same cycle as the end pulse. The second case chains the deferred fold and the closing lookup within one clock. The bench sends every sweep packet twice. The first time, start and end are separate cycles. The second time, the first byte is merged with start and the last byte with end. Both runs must give the same register value and ok flag as a bit-serial CRC model computed in the bench.

// File: rtl/usb_crc16_pkg.sv
package usb_crc16_pkg;

    localparam int          BYTE_W        = 8;
    localparam int          CRC_W         = 2 * BYTE_W;
    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;
    localparam logic [15:0] CRC_RESIDUE   = 16'hB001;
    localparam logic [15:0] CRC_PRELOAD   = 16'hFE54;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } crc_pair_t;

    // One table entry: the index pushed through eight reflected shifts.
    function automatic logic [CRC_W-1:0] lut_entry(input logic [BYTE_W-1:0] idx,
                                                   input logic [CRC_W-1:0]  poly);
        logic [CRC_W-1:0] r;
        r = {{BYTE_W{1'b0}}, idx};
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/usb_crc16_lut_step.sv
module usb_crc16_lut_step
    import usb_crc16_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY_REFL
) (
    input  crc_pair_t cur_i,
    output crc_pair_t nxt_o
);
    logic [CRC_W-1:0] entry;

    always_comb begin
        entry    = lut_entry(cur_i.lo, POLY);
        nxt_o.hi = entry[CRC_W-1:BYTE_W];
        nxt_o.lo = entry[BYTE_W-1:0] ^ cur_i.hi;
    end
endmodule

// File: rtl/usb_crc16_state_reg.sv
module usb_crc16_state_reg
    import usb_crc16_pkg::*;
#(
    parameter logic [CRC_W-1:0] PRELOAD = CRC_PRELOAD
) (
    input  logic      clk,
    input  logic      rst,
    input  crc_pair_t pair_d,
    input  logic      active_d,
    input  logic      done_d,
    input  logic      ok_d,
    output crc_pair_t pair_q,
    output logic      active_q,
    output logic      done_q,
    output logic      ok_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q   <= crc_pair_t'(PRELOAD);
            active_q <= 1'b0;
            done_q   <= 1'b0;
            ok_q     <= 1'b0;
        end else begin
            pair_q   <= pair_d;
            active_q <= active_d;
            done_q   <= done_d;
            ok_q     <= ok_d;
        end
    end
endmodule

// File: rtl/usb_crc16_checker.sv
module usb_crc16_checker
    import usb_crc16_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY    = CRC_POLY_REFL,
    parameter logic [CRC_W-1:0] RESIDUE = CRC_RESIDUE,
    parameter logic [CRC_W-1:0] PRELOAD = CRC_PRELOAD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              end_i,
    output logic              crc_ok_o,
    output logic              done_o,
    output logic [CRC_W-1:0]  crc_reg_o
);
    crc_pair_t pair_q, base, stepped, folded, closed, pair_d;
    logic      active_q, active_d, in_pkt, take_byte, take_end;
    logic      done_q, ok_q, ok_d;

    // A start pulse replaces the register with the deferred-fold preload.
    always_comb begin
        base      = start_i ? crc_pair_t'(PRELOAD) : pair_q;
        in_pkt    = start_i | active_q;
        take_byte = byte_valid_i & in_pkt;
        take_end  = end_i & active_q & ~start_i;
    end

    // Fold the byte held in lo, then park the new byte in lo.
    usb_crc16_lut_step #(.POLY(POLY)) u_fold_step (
        .cur_i (base),
        .nxt_o (stepped)
    );

    always_comb begin
        folded = base;
        if (take_byte) begin
            folded.hi = stepped.hi;
            folded.lo = stepped.lo ^ byte_i;
        end
    end

    // Closing lookup flushes the parked last byte.
    usb_crc16_lut_step #(.POLY(POLY)) u_close_step (
        .cur_i (folded),
        .nxt_o (closed)
    );

    always_comb begin
        pair_d   = take_end ? closed : folded;
        active_d = start_i | (active_q & ~take_end);
        ok_d     = take_end & (closed == RESIDUE);
    end

    usb_crc16_state_reg #(.PRELOAD(PRELOAD)) u_state (
        .clk      (clk),
        .rst      (rst),
        .pair_d   (pair_d),
        .active_d (active_d),
        .done_d   (take_end),
        .ok_d     (ok_d),
        .pair_q   (pair_q),
        .active_q (active_q),
        .done_q   (done_q),
        .ok_q     (ok_q)
    );

    assign crc_reg_o = pair_q;
    assign done_o    = done_q;
    assign crc_ok_o  = ok_q;
endmodule

// File: rtl/usb_crc16_checker_sva.sv
module usb_crc16_checker_sva
    import usb_crc16_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             byte_valid_i,
    input logic             end_i,
    input logic             active_i,
    input logic             crc_ok_i,
    input logic             done_i,
    input logic [CRC_W-1:0] crc_reg_i
);
    // R5: ok only accompanies done
    a_r5_ok_needs_done: assert property (@(posedge clk) disable iff (rst)
        crc_ok_i |-> done_i);

    // R4: done lasts a single cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !done_i);

    // R4: done follows an end pulse
    a_r4_done_after_end: assert property (@(posedge clk) disable iff (rst)
        done_i |-> $past(end_i));

    // R3: ok agrees with the residue in the done cycle
    a_r3_residue_ok: assert property (@(posedge clk) disable iff (rst)
        done_i |-> (crc_ok_i == (crc_reg_i == CRC_RESIDUE)));

    // R6: a bare start preloads the register
    a_r6_preload: assert property (@(posedge clk) disable iff (rst)
        (start_i && !byte_valid_i) |=> (crc_reg_i == CRC_PRELOAD));

    // R9: nothing moves the register while no packet is open
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!active_i && !start_i) |=> $stable(crc_reg_i));

    // R10: a stray end pulse gives no done
    a_r10_stray_end: assert property (@(posedge clk) disable iff (rst)
        (end_i && (!active_i || start_i)) |=> !done_i);
endmodule

bind usb_crc16_checker usb_crc16_checker_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .end_i        (end_i),
    .active_i     (active_q),
    .crc_ok_i     (crc_ok_o),
    .done_i       (done_o),
    .crc_reg_i    (crc_reg_o)
);

// File: tb/usb_crc16_checker_tb.sv
`timescale 1ns/1ps
module usb_crc16_checker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic        end_i = 1'b0;
    logic        crc_ok_o, done_o;
    logic [15:0] crc_reg_o;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  pkt [0:15];
    int          plen = 0;
    logic [15:0] seed = 16'hACE1;

    always #2.5 clk = ~clk;

    usb_crc16_checker u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .end_i(end_i), .crc_ok_o(crc_ok_o), .done_o(done_o),
        .crc_reg_o(crc_reg_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-serial reference over pkt[0..n-1]
    function automatic logic [15:0] ser_crc(input int n);
        logic [15:0] c;
        logic        fb;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[0] ^ pkt[i][b];
                c  = c >> 1;
                if (fb) c = c ^ 16'hA001;
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] next_rand();
        seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
        return seed[7:0] ^ seed[15:8];
    endfunction

    task automatic build(input int n, input int pat, input bit corrupt);
        logic [15:0] c;
        logic [7:0]  r;
        for (int i = 0; i < n; i++)
            pkt[i] = (pat == 0) ? next_rand() : (pat == 1) ? 8'hFF : 8'h00;
        c = ser_crc(n);
        pkt[n]   = ~c[7:0];
        pkt[n+1] = ~c[15:8];
        plen = n + 2;
        if (corrupt) begin
            r = next_rand();
            pkt[int'(r) % plen] ^= (8'h01 << r[2:0]);
        end
    endtask

    // merged: first byte rides on start, last byte rides on end
    task automatic send(input bit merged, input bit opened, input string tag);
        int          i0;
        logic [15:0] e;
        e  = ser_crc(plen);
        i0 = 0;
        if (!opened) begin
            start_i = 1'b1;
            if (merged) begin
                byte_valid_i = 1'b1;
                byte_i = pkt[0];
                i0 = 1;
            end
            @(negedge clk);
            start_i = 1'b0;
            byte_valid_i = 1'b0;
        end
        for (int i = i0; i < plen; i++) begin
            byte_valid_i = 1'b1;
            byte_i = pkt[i];
            if (merged && i == plen - 1) end_i = 1'b1;
            @(negedge clk);
            byte_valid_i = 1'b0;
            end_i = 1'b0;
            if (i % 3 == 1 && !(merged && i == plen - 1)) @(negedge clk);
        end
        if (!merged) begin
            end_i = 1'b1;
            @(negedge clk);
            end_i = 1'b0;
        end
        chk({tag, " R4 done pulse"}, 32'(done_o), 32'd1);
        chk({tag, " R2 register"}, 32'(crc_reg_o), 32'(e));
        chk({tag, " R3 ok flag"}, 32'(crc_ok_o), 32'(e == 16'hB001));
        @(negedge clk);
        chk({tag, " R4 done drop"}, 32'(done_o), 32'd0);
        chk({tag, " R5 ok drop"}, 32'(crc_ok_o), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        chk("R1 reset reg", 32'(crc_reg_o), 32'h0000FE54);
        chk("R1 reset done", 32'(done_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset reg", 32'(crc_reg_o), 32'h0000FE54);
        chk("R1 after reset ok", 32'(crc_ok_o), 32'd0);

        // R6: bare start, then empty packet closes to 0xFFFF
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R6 preload", 32'(crc_reg_o), 32'h0000FE54);
        plen = 0;
        end_i = 1'b1;
        @(negedge clk);
        end_i = 1'b0;
        chk("R2 empty close", 32'(crc_reg_o), 32'h0000FFFF);
        chk("R3 empty not ok", 32'(crc_ok_o), 32'd0);
        chk("R4 empty done", 32'(done_o), 32'd1);

        // Sweep: lengths, patterns, separate vs merged (R7, R8), good vs bad
        for (int n = 0; n <= 8; n++)
            for (int pat = 0; pat < 3; pat++)
                for (int bad = 0; bad < 2; bad++)
                    for (int m = 0; m < 2; m++) begin
                        build(n, pat, bit'(bad));
                        send(bit'(m), 1'b0, m ? "R7 R8 merged" : "R2 separate");
                    end

        // R9: bytes while no packet is open are ignored
        held = crc_reg_o;
        for (int k = 0; k < 3; k++) begin
            byte_valid_i = 1'b1;
            byte_i = 8'h5A + 8'(k);
            @(negedge clk);
            chk("R9 idle byte ignored", 32'(crc_reg_o), 32'(held));
        end
        byte_valid_i = 1'b0;

        // R10: stray end pulse
        end_i = 1'b1;
        @(negedge clk);
        end_i = 1'b0;
        @(negedge clk);
        chk("R10 stray end no done", 32'(done_o), 32'd0);
        chk("R10 stray end reg", 32'(crc_reg_o), 32'(held));

        // R10: start with end opens the packet, end ignored
        start_i = 1'b1;
        end_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        end_i = 1'b0;
        chk("R10 start+end no done", 32'(done_o), 32'd0);
        chk("R6 start+end preload", 32'(crc_reg_o), 32'h0000FE54);
        build(5, 0, 1'b0);
        send(1'b0, 1'b1, "R10 reopened");

        // R6: restart in the middle of a packet
        build(3, 0, 1'b1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        byte_valid_i = 1'b1;
        byte_i = 8'hC3;
        @(negedge clk);
        byte_valid_i = 1'b0;
        build(6, 0, 1'b0);
        send(1'b0, 1'b0, "R6 restart");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule